// File: doc/BRIEF.md
# Advanced Load Address Table

This block tracks loads that were issued early, ahead of stores that might alias them. Each such load leaves an entry holding its destination register tag and the byte range it read. Every local store and every write snooped from another processor is compared by byte range against all live entries, and any entry it overlaps is dropped. A later check names a register tag. The block answers one cycle later with a hit, which means the early value is still good, or a miss, which means the pipeline must reload or branch to recovery code.

The table holds `ENTRIES` slots, eight by default. A slot holds at most one entry per register tag, so a second early load to a tag already present takes over that slot. When every slot is in use, a new load silently displaces the oldest entry. A check either keeps the entry it finds or frees it.

Within one cycle the block applies events in this order:
1. Store and snoop invalidations.
2. The check lookup and its optional release.
3. The insertion of a new load.

Each slot runs a two-state machine, `ENT_FREE` and `ENT_LIVE`, with these transitions:
- ARM: `ENT_FREE` to `ENT_LIVE` when the slot is chosen for a load.
- KILL: `ENT_LIVE` to `ENT_FREE` when a store or snoop overlaps the slot.
- RELEASE: `ENT_LIVE` to `ENT_FREE` when a clearing check finds the slot.
- REPLACE: `ENT_LIVE` to `ENT_LIVE` with new contents, when a load to the same tag arrives or when the slot is the oldest and is evicted.
- HOLD: the slot keeps its state in every other case.

Top module: `alat_table`

## Requirements
- R1: After reset every slot is empty, `chk_done` is 0, and a check of any tag reports a miss.
- R2: A check asserted in cycle N produces `chk_done`=1 in cycle N+1 and only then. `chk_hit` is valid with it.
- R3: A check of a tag that has no live entry reports a miss, even while other tags are live.
- R4: A local store removes every entry whose byte range overlaps its own. The size code maps 0, 1, 2 and 3 to 1, 2, 4 and 8 bytes starting at the address. A store whose range only abuts an entry's range leaves that entry alive.
- R5: A snooped write removes overlapping entries by the same byte-range rule as a local store, and leaves non-overlapping entries alive.
- R6: A check with `chk_clear`=1 that hits frees the entry, so the next check of that tag misses. A check with `chk_clear`=0 leaves the entry in place.
- R7: A load to a tag that is already live replaces that entry. The old address range no longer guards the tag, and the new range does.
- R8: When all slots are live and a load to a new tag arrives, the entry inserted longest ago is dropped and all the others stay live.
- R9: When a store or snoop and a check arrive in the same cycle, the invalidation is applied first. A check of an overlapped entry then misses.
- R10: A check and a load to the same absent tag in the same cycle report a miss, and the load is recorded afterwards.
- R11: A slot freed by a clearing check can be reused without evicting anything, even when the clearing check and the load share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | An early load is recorded this cycle |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | First byte address of the load |
| ld_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| st_valid | input | 1 | A local store occurs this cycle |
| st_addr | input | ADDR_W | First byte address of the store |
| st_size | input | 2 | Store size code |
| snp_valid | input | 1 | A write from another processor is observed |
| snp_addr | input | ADDR_W | First byte address of the snooped write |
| snp_size | input | 2 | Snooped write size code |
| chk_valid | input | 1 | A check is requested this cycle |
| chk_tag | input | TAG_W | Register tag being checked |
| chk_clear | input | 1 | 1: free the entry after lookup; 0: keep it |
| chk_done | output | 1 | The check result is valid (one cycle after `chk_valid`) |
| chk_hit | output | 1 | 1: the early value is still valid; 0: reload or recover |

## Verification
The hardest cases to reach are full-table eviction and ageing after holes have opened. Only the order in which tags were inserted decides which entry goes, and that order is visible only through later checks. The stimulus fills all eight slots with distinct tags and overflows them twice, probing each tag without clearing it. It then frees one slot with a clearing check and loads again, both in separate cycles and in the same cycle, to show that the freed slot is reused and the oldest surviving entry stays. Same-cycle collisions of store with check and of load with check are driven explicitly to pin down the order in which events are applied.

// File: rtl/alat_pkg.sv
package alat_pkg;

    // Lifecycle of one table slot
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_LIVE = 1'b1
    } ent_state_e;

endpackage

// File: rtl/alat_span_cmp.sv
// Byte-range overlap test between two accesses of 1/2/4/8 bytes.
module alat_span_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a_base,
    input  logic [1:0]        a_sz,
    input  logic [ADDR_W-1:0] b_base,
    input  logic [1:0]        b_sz,
    output logic              meet
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = {1'b0, a_base};
        b_lo = {1'b0, b_base};
        a_hi = a_lo + (EXT_W'(1) << a_sz);
        b_hi = b_lo + (EXT_W'(1) << b_sz);
        meet = (a_lo < b_hi) && (b_lo < a_hi);
    end
endmodule

// File: rtl/alat_age.sv
// Pairwise age matrix: older_q[i][j] = 1 when slot i was filled before slot j.
module alat_age #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc,
    input  logic [N-1:0] cand,
    output logic [N-1:0] oldest
);
    logic [N-1:0] older_q [N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc[i])
                        older_q[i][j] <= 1'b0;
                    else if (alloc[j] && (i != j))
                        older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            oldest[i] = cand[i];
            for (int j = 0; j < N; j++) begin
                if ((i != j) && cand[j] && !older_q[i][j])
                    oldest[i] = 1'b0;
            end
        end
    end

    // R8
    oldest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oldest));

    // R8
    oldest_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> (|oldest));
endmodule

// File: rtl/alat_slot.sv
// One table slot with its own FREE/LIVE state machine.
module alat_slot
    import alat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [1:0]        snp_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              alloc,
    output logic              chk_match,
    output logic              ld_match,
    output logic              keep
);
    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;

    logic st_meet, snp_meet;
    logic live, kill, survive, release_now;

    alat_span_cmp #(.ADDR_W(ADDR_W)) st_cmp_i (
        .a_base(addr_q), .a_sz(size_q),
        .b_base(st_addr), .b_sz(st_size),
        .meet(st_meet)
    );

    alat_span_cmp #(.ADDR_W(ADDR_W)) snp_cmp_i (
        .a_base(addr_q), .a_sz(size_q),
        .b_base(snp_addr), .b_sz(snp_size),
        .meet(snp_meet)
    );

    // Outputs: invalidation first, then lookup/release
    always_comb begin
        live        = (state_q == ENT_LIVE);
        kill        = live && ((st_valid && st_meet) || (snp_valid && snp_meet));
        survive     = live && !kill;
        chk_match   = survive && chk_valid && (tag_q == chk_tag);
        release_now = chk_match && chk_clear;
        keep        = survive && !release_now;
        ld_match    = survive && ld_valid && (tag_q == ld_tag);
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: state_d = alloc ? ENT_LIVE : ENT_FREE;
            ENT_LIVE: state_d = (alloc || keep) ? ENT_LIVE : ENT_FREE;
            default:  state_d = ENT_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // Payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            addr_q <= '0;
            size_q <= '0;
        end else if (alloc) begin
            tag_q  <= ld_tag;
            addr_q <= ld_addr;
            size_q <= ld_size;
        end
    end

    // R4
    kill_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !alloc) |=> (state_q == ENT_FREE));

    // R6
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_now && !alloc) |=> (state_q == ENT_FREE));

    // R7
    alloc_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (state_q == ENT_LIVE) && (tag_q == $past(ld_tag)));
endmodule

// File: rtl/alat_table.sv
// Associative table of early loads, checked by register tag.
module alat_table #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [1:0]        snp_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    output logic              chk_done,
    output logic              chk_hit
);
    logic [ENTRIES-1:0] chk_match_v, ld_match_v, keep_v, alloc_v;
    logic [ENTRIES-1:0] free_v, first_free_v, oldest_v;
    logic               done_q, hit_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        alat_slot #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .st_valid  (st_valid),
            .st_addr   (st_addr),
            .st_size   (st_size),
            .snp_valid (snp_valid),
            .snp_addr  (snp_addr),
            .snp_size  (snp_size),
            .chk_valid (chk_valid),
            .chk_tag   (chk_tag),
            .chk_clear (chk_clear),
            .ld_valid  (ld_valid),
            .ld_tag    (ld_tag),
            .ld_addr   (ld_addr),
            .ld_size   (ld_size),
            .alloc     (alloc_v[g]),
            .chk_match (chk_match_v[g]),
            .ld_match  (ld_match_v[g]),
            .keep      (keep_v[g])
        );
    end

    alat_age #(.N(ENTRIES)) age_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (alloc_v),
        .cand   (keep_v),
        .oldest (oldest_v)
    );

    // Slot choice: same tag, else lowest free, else oldest
    always_comb begin
        free_v       = ~keep_v;
        first_free_v = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_v[i]) first_free_v = ENTRIES'(1) << i;
        end
        alloc_v = '0;
        if (ld_valid) begin
            if (|ld_match_v)  alloc_v = ld_match_v;
            else if (|free_v) alloc_v = first_free_v;
            else              alloc_v = oldest_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            done_q <= chk_valid;
            hit_q  <= chk_valid && (|chk_match_v);
        end
    end

    assign chk_done = done_q;
    assign chk_hit  = hit_q;

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done && !chk_hit);

    // R7
    tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_match_v) && $onehot0(ld_match_v));

    // R8
    one_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($countones(alloc_v) == 1));
endmodule

// File: tb/alat_table_tb_top.sv
module alat_table_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid, st_valid, snp_valid, chk_valid, chk_clear;
    logic [6:0]  ld_tag, chk_tag;
    logic [31:0] ld_addr, st_addr, snp_addr;
    logic [1:0]  ld_size, st_size, snp_size;
    logic        chk_done, chk_hit;

    int errors = 0;
    int checks = 0;
    bit    exp_q[$];
    string req_q[$];

    always #5 clk = ~clk;

    alat_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_size(snp_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
        .chk_done(chk_done), .chk_hit(chk_hit)
    );

    task automatic idle_inputs();
        ld_valid = 0; st_valid = 0; snp_valid = 0; chk_valid = 0; chk_clear = 0;
        ld_tag = 0; chk_tag = 0; ld_addr = 0; st_addr = 0; snp_addr = 0;
        ld_size = 0; st_size = 0; snp_size = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic put_ld(input logic [6:0] t, input logic [31:0] a, input logic [1:0] s);
        ld_valid = 1; ld_tag = t; ld_addr = a; ld_size = s;
    endtask

    task automatic put_st(input logic [31:0] a, input logic [1:0] s);
        st_valid = 1; st_addr = a; st_size = s;
    endtask

    task automatic put_snp(input logic [31:0] a, input logic [1:0] s);
        snp_valid = 1; snp_addr = a; snp_size = s;
    endtask

    // Driver: request a check and queue the expected answer
    task automatic put_chk(input logic [6:0] t, input logic clr, input bit exp, input string req);
        chk_valid = 1; chk_tag = t; chk_clear = clr;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    // Monitor: compare each response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && chk_done === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response: got hit=%0b, expected no response", chk_hit);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                if (chk_hit !== e) begin
                    errors++;
                    $display("FAIL %s check result: got hit=%0b, expected hit=%0b", r, chk_hit, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (chk_done !== 1'b0 || chk_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: got done=%0b hit=%0b, expected 0 0", chk_done, chk_hit);
        end
        rst_n = 1;
        step();
        put_chk(7'd3, 0, 0, "R1"); step();

        // R2 / R3
        put_ld(7'd3, 32'h100, 2'd3); step();
        put_chk(7'd3, 0, 1, "R2"); step();
        put_chk(7'd4, 0, 0, "R3"); step();

        // R4: abutting store keeps, overlapping store kills
        put_st(32'h108, 2'd2); step();
        put_chk(7'd3, 0, 1, "R4"); step();
        put_st(32'h107, 2'd0); step();
        put_chk(7'd3, 0, 0, "R4"); step();

        // R5: snoop writes
        put_ld(7'd5, 32'h200, 2'd1); step();
        put_snp(32'h1FE, 2'd1); step();
        put_snp(32'h1FC, 2'd2); step();
        put_chk(7'd5, 0, 1, "R5"); step();
        put_snp(32'h201, 2'd0); step();
        put_chk(7'd5, 0, 0, "R5"); step();

        // R6: clear vs keep
        put_ld(7'd6, 32'h300, 2'd2); step();
        put_chk(7'd6, 1, 1, "R6"); step();
        put_chk(7'd6, 0, 0, "R6"); step();
        put_ld(7'd7, 32'h310, 2'd2); step();
        put_chk(7'd7, 0, 1, "R6"); step();
        put_chk(7'd7, 0, 1, "R6"); step();

        // R7: replacement by same tag
        put_ld(7'd7, 32'h400, 2'd2); step();
        put_st(32'h310, 2'd2); step();
        put_chk(7'd7, 0, 1, "R7"); step();
        put_st(32'h402, 2'd0); step();
        put_chk(7'd7, 0, 0, "R7"); step();

        // R8: fill and overflow
        for (int i = 0; i < 9; i++) begin
            put_ld(7'(10 + i), 32'h1000 + 32'(16 * i), 2'd3); step();
        end
        put_chk(7'd10, 0, 0, "R8"); step();
        for (int i = 11; i < 19; i++) begin
            put_chk(7'(i), 0, 1, "R8"); step();
        end
        put_ld(7'd19, 32'h1100, 2'd3); step();
        put_chk(7'd11, 0, 0, "R8"); step();
        put_chk(7'd12, 0, 1, "R8"); step();

        // R11: freed slot reused without eviction
        put_chk(7'd12, 1, 1, "R11"); step();
        put_ld(7'd20, 32'h1200, 2'd3); step();
        put_chk(7'd13, 0, 1, "R11"); step();
        put_chk(7'd20, 0, 1, "R11"); step();
        put_chk(7'd13, 1, 1, "R11"); put_ld(7'd21, 32'h1300, 2'd3); step();
        put_chk(7'd14, 0, 1, "R11"); step();
        put_chk(7'd21, 0, 1, "R11"); step();
        put_chk(7'd13, 0, 0, "R11"); step();

        // R9: store/snoop and check in one cycle
        put_ld(7'd30, 32'h5000, 2'd2); step();
        put_st(32'h5003, 2'd0); put_chk(7'd30, 0, 0, "R9"); step();
        put_ld(7'd31, 32'h6000, 2'd2); step();
        put_snp(32'h7000, 2'd3); put_chk(7'd31, 0, 1, "R9"); step();
        put_snp(32'h6002, 2'd1); put_chk(7'd31, 0, 0, "R9"); step();

        // R10: load and check of an absent tag in one cycle
        put_ld(7'd40, 32'h9000, 2'd0); put_chk(7'd40, 0, 0, "R10"); step();
        put_chk(7'd40, 0, 1, "R10"); step();

        // R4: size codes near a 1-byte entry
        put_ld(7'd41, 32'h8000, 2'd0); step();
        put_st(32'h7FFC, 2'd2); step();
        put_st(32'h7FF8, 2'd3); step();
        put_chk(7'd41, 0, 1, "R4"); step();
        put_st(32'h7FFF, 2'd1); step();
        put_chk(7'd41, 0, 0, "R4"); step();

        step(); step();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses: got %0d pending, expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule